// File: doc/BRIEF.md
# 1.5-Bit Pipeline Digital Correction with Selectable Resolution

This block sits behind the analog stages of a pipelined converter in which each full stage resolves 1.5 bits. There are nine identical full stages and a closing single-comparator stage. Each full stage reports a 2-bit code: 00 means the residue lay below the lower threshold, 01 means it lay between the thresholds, and 10 means it lay above the upper threshold. The closing comparator reports one bit. Codes for one sample reach the block one clock apart, stage 1 first. The block delays each stage's code until all codes of the same sample line up. It then adds them with a one-bit overlap between neighbours, so that comparator offsets smaller than a quarter of full scale leave no trace in the result.

The resolution N (6 to 10 bits) is chosen at run time. For an N-bit setting, full stages 1 to N-1 take part. The closing comparator bit is expected in the cycle after stage N-1 delivers, and it corrects that last enabled full stage. Stages N to 9 are ignored.

A small controller has two states, FLUSH and RUN. Reset and every change of the selected resolution lead to FLUSH (transition "reconfig"). The controller stays in FLUSH for the pipeline latency and then moves to RUN (transition "flush_done"). While in FLUSH, no valid result leaves the block. An end-of-range flag marks results that sit at the bottom or top code, where the input may lie outside the quantisation range.

Top module: `rc_top`

## Requirements
- R1: The result for a sample whose stage-1 code is sampled at clock edge E appears on the outputs after edge E+N-1.
- R2: The output word equals the sum over k=1..N-1 of code_k·2^(N-1-k), plus the comparator bit. It is right-justified in `out_code`, and the bits above N are zero.
- R3: A stage code of 11 is treated as 10.
- R4: Codes on stages N to 9 have no effect on the result for resolution N. The comparator bit is taken in the cycle after stage N-1.
- R5: A resolution select below 6 acts as 6, and one above 10 acts as 10.
- R6: With residues produced by stages whose comparator thresholds are displaced by less than a quarter of full scale, the output equals the ideal N-bit quantisation of the input, clamped to 0 and 2^N-1.
- R7: `out_ovf` is high exactly when a valid result is all zeros or all ones for resolution N. It is never high without `out_vld`.
- R8: `out_vld` reproduces the stage-1 `in_vld` with the latency of R1.
- R9: After a change of the effective resolution, seen at edge E0, `out_vld` stays low after edges E0+1 to E0+N-1. It follows R8 again from edge E0+N onwards.
- R10: During reset, `out_vld`, `out_ovf` and `out_code` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_sel | input | 4 | Requested resolution in bits (6..10) |
| in_vld | input | 1 | Marks the stage-1 code of the current cycle as a real sample |
| stg_code | input | 18 | Stage k code in bits [2k-1:2k-2]; 00 low, 01 mid, 10 high |
| fin_bit | input | 1 | Closing comparator bit for the sample ending in this cycle |
| out_vld | output | 1 | Corrected result valid |
| out_code | output | 10 | Corrected N-bit result, right-justified |
| out_ovf | output | 1 | Result sits at the bottom or top end code |

## Verification
The hardest condition to reach from the ports is offset absorption. It only shows when stage codes come from residues produced with displaced thresholds, sample by sample, while the codes of neighbouring samples overlap in time on the stage inputs. The bench runs a scaled-integer residue model of the analog chain with random threshold offsets per stage. It sweeps the input slightly past both ends of the range and skews each stage's codes into the cycle that stage would deliver them. The flush boundary is reached by changing the resolution with valid samples streaming. The sample captured in the change cycle must be suppressed, while the next sample must appear.

// File: rtl/rc_pkg.sv
`timescale 1ns/1ps
package rc_pkg;

    typedef enum logic {
        ST_FLUSH = 1'b0,
        ST_RUN   = 1'b1
    } rc_state_e;

    localparam logic [1:0] CODE_TOP = 2'b10;

    // An illegal 11 from a stage is folded onto the top legal code.
    function automatic logic [1:0] fix_code(input logic [1:0] c);
        return (c == 2'b11) ? CODE_TOP : c;
    endfunction

endpackage

// File: rtl/rc_ctrl.sv
`timescale 1ns/1ps
module rc_ctrl
    import rc_pkg::*;
#(
    parameter int RES_MIN = 6,
    parameter int RES_MAX = 10,
    parameter int RSEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RSEL_W-1:0] res_sel,
    output logic [RSEL_W-1:0] res_q,
    output logic              run
);
    localparam logic [RSEL_W-1:0] LO = RSEL_W'(RES_MIN);
    localparam logic [RSEL_W-1:0] HI = RSEL_W'(RES_MAX);

    rc_state_e         st, st_nxt;
    logic [RSEL_W-1:0] cnt, cnt_nxt, res_nxt, want, flush_last;

    // Requested resolution, clamped to the supported range.
    always_comb begin
        if (res_sel < LO)      want = LO;
        else if (res_sel > HI) want = HI;
        else                   want = res_sel;
    end

    assign flush_last = res_q - RSEL_W'(2);

    // Next-state logic: reconfig from any state, flush_done from FLUSH.
    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        res_nxt = res_q;
        if (want != res_q) begin
            st_nxt  = ST_FLUSH;
            cnt_nxt = '0;
            res_nxt = want;
        end else begin
            unique case (st)
                ST_FLUSH: begin
                    if (cnt == flush_last) st_nxt = ST_RUN;
                    else                   cnt_nxt = cnt + RSEL_W'(1);
                end
                ST_RUN: st_nxt = ST_RUN;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_FLUSH;
            cnt   <= '0;
            res_q <= HI;
        end else begin
            st    <= st_nxt;
            cnt   <= cnt_nxt;
            res_q <= res_nxt;
        end
    end

    // Outputs.
    always_comb begin
        unique case (st)
            ST_FLUSH: run = 1'b0;
            ST_RUN:   run = 1'b1;
        endcase
    end

endmodule

// File: rtl/rc_align.sv
`timescale 1ns/1ps
module rc_align
    import rc_pkg::*;
#(
    parameter int RES_MAX = 10,
    parameter int RSEL_W  = 4,
    localparam int NSTG   = RES_MAX - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RSEL_W-1:0] res_q,
    input  logic              in_vld,
    input  logic [2*NSTG-1:0] stg_code,
    output logic [2*NSTG-1:0] al_code,
    output logic              al_vld
);
    // Valid travels with stage 1, so it needs the deepest line.
    logic [NSTG-1:0] vline;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vline <= '0;
        else        vline <= {vline[NSTG-2:0], in_vld};
    end

    always_comb begin
        al_vld = 1'b0;
        for (int j = 0; j < NSTG; j++)
            if (j == int'(res_q) - 2) al_vld = vline[j];
    end

    // Stage gi+1 arrives gi cycles after stage 1, so its line is shorter.
    for (genvar gi = 0; gi < NSTG; gi++) begin : g_stage
        localparam int DEP = NSTG - gi;
        logic [DEP-1:0][1:0] line;
        logic [1:0]          sel;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                line <= '0;
            end else begin
                line[0] <= fix_code(stg_code[2*gi +: 2]);
                for (int j = 1; j < DEP; j++) line[j] <= line[j-1];
            end
        end

        // A stage past the enabled set finds no tap and yields zero.
        always_comb begin
            sel = 2'b00;
            for (int j = 0; j < DEP; j++)
                if (j == int'(res_q) - 2 - gi) sel = line[j];
        end

        assign al_code[2*gi +: 2] = sel;
    end

endmodule

// File: rtl/rc_combine.sv
`timescale 1ns/1ps
module rc_combine #(
    parameter int RES_MAX = 10,
    parameter int RSEL_W  = 4,
    localparam int NSTG   = RES_MAX - 1,
    localparam int ACC_W  = RES_MAX + 1
) (
    input  logic [RSEL_W-1:0]  res_q,
    input  logic [2*NSTG-1:0]  al_code,
    input  logic               fin_bit,
    output logic [RES_MAX-1:0] word,
    output logic               end_hit
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] top;
    int               n;

    // Overlapped sum: each stage one bit above the next, comparator at LSB.
    always_comb begin
        n   = int'(res_q);
        acc = '0;
        for (int i = 0; i < NSTG; i++)
            if (i <= n - 2)
                acc = acc + (ACC_W'(al_code[2*i +: 2]) << (n - 2 - i));
        acc = acc + ACC_W'(fin_bit);
    end

    always_comb begin
        top     = (ACC_W'(1) << res_q) - ACC_W'(1);
        end_hit = (acc == '0) || (acc == top);
        word    = acc[RES_MAX-1:0];
    end

endmodule

// File: rtl/rc_top.sv
`timescale 1ns/1ps
module rc_top
    import rc_pkg::*;
#(
    parameter int  RES_MIN = 6,
    parameter int  RES_MAX = 10,
    localparam int RSEL_W  = $clog2(RES_MAX + 1),
    localparam int NSTG    = RES_MAX - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RSEL_W-1:0]  res_sel,
    input  logic               in_vld,
    input  logic [2*NSTG-1:0]  stg_code,
    input  logic               fin_bit,
    output logic               out_vld,
    output logic [RES_MAX-1:0] out_code,
    output logic               out_ovf
);
    logic [RSEL_W-1:0]  res_q;
    logic               run;
    logic [2*NSTG-1:0]  al_code;
    logic               al_vld;
    logic [RES_MAX-1:0] word;
    logic               end_hit;

    rc_ctrl #(.RES_MIN(RES_MIN), .RES_MAX(RES_MAX), .RSEL_W(RSEL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .res_sel(res_sel), .res_q(res_q), .run(run)
    );

    rc_align #(.RES_MAX(RES_MAX), .RSEL_W(RSEL_W)) u_align (
        .clk(clk), .rst_n(rst_n), .res_q(res_q), .in_vld(in_vld),
        .stg_code(stg_code), .al_code(al_code), .al_vld(al_vld)
    );

    rc_combine #(.RES_MAX(RES_MAX), .RSEL_W(RSEL_W)) u_comb (
        .res_q(res_q), .al_code(al_code), .fin_bit(fin_bit),
        .word(word), .end_hit(end_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_code <= '0;
            out_ovf  <= 1'b0;
        end else begin
            out_vld  <= run & al_vld;
            out_code <= word;
            out_ovf  <= run & al_vld & end_hit;
        end
    end

endmodule

module rc_top_chk #(
    parameter int  RES_MIN = 6,
    parameter int  RES_MAX = 10,
    localparam int RSEL_W  = $clog2(RES_MAX + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [RSEL_W-1:0]  res_q,
    input logic               run,
    input logic               out_vld,
    input logic [RES_MAX-1:0] out_code,
    input logic               out_ovf
);
    logic [RSEL_W-1:0] res_d;
    logic [RES_MAX:0]  full_w;
    logic [RES_MAX:0]  ext;

    // Resolution that produced the word now on out_code.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_d <= RSEL_W'(RES_MAX);
        else        res_d <= res_q;
    end

    always_comb begin
        full_w = ({{RES_MAX{1'b0}}, 1'b1} << res_d) - {{RES_MAX{1'b0}}, 1'b1};
        ext    = {1'b0, out_code};
    end

    p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !out_vld);

    p_ovf_needs_vld_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |-> out_vld);

    p_ovf_end_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |-> (ext == '0 || ext == full_w));

    p_code_fits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ext <= full_w);

    p_res_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(res_q) >= RES_MIN) && (int'(res_q) <= RES_MAX));

endmodule

bind rc_top rc_top_chk #(.RES_MIN(RES_MIN), .RES_MAX(RES_MAX)) u_chk (
    .clk(clk), .rst_n(rst_n), .res_q(res_q), .run(run),
    .out_vld(out_vld), .out_code(out_code), .out_ovf(out_ovf)
);

// File: tb/tb_rc_top.sv
`timescale 1ns/1ps
module tb_rc_top;
    localparam int NSTG = 9;
    localparam int MAXS = 600;
    localparam longint FS = 64'sd1 << 20;   // full scale in model units

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  res_sel = 4'd10;
    logic        in_vld = 1'b0;
    logic [17:0] stg_code = '0;
    logic        fin_bit = 1'b0;
    logic        out_vld;
    logic [9:0]  out_code;
    logic        out_ovf;

    rc_top #(.RES_MIN(6), .RES_MAX(10)) dut (
        .clk(clk), .rst_n(rst_n), .res_sel(res_sel), .in_vld(in_vld),
        .stg_code(stg_code), .fin_bit(fin_bit),
        .out_vld(out_vld), .out_code(out_code), .out_ovf(out_ovf)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int cd [MAXS][10];
    bit bb [MAXS];
    bit vl [MAXS];
    int ex [MAXS];
    bit eo [MAXS];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Behavioural residue chain with offset thresholds (R6).
    task automatic gen_analog(input int n, input int ns);
        longint hi [10];
        longint lo [10];
        for (int k = 1; k < 10; k++) begin
            hi[k] = FS / 4 + longint'($urandom % (1 << 18)) - (1 << 17);
            lo[k] = -FS / 4 + longint'($urandom % (1 << 18)) - (1 << 17);
        end
        for (int s = 0; s < ns; s++) begin
            longint v = -(FS + FS / 4) + (longint'(s) * (2 * FS + FS / 2)) / longint'(ns - 1);
            longint r = v;
            longint e;
            for (int k = 1; k <= n - 1; k++) begin
                int c = (r > hi[k]) ? 2 : ((r < lo[k]) ? 0 : 1);
                cd[s][k] = c;
                r = 2 * r - longint'(c - 1) * FS;
            end
            bb[s] = (r >= 0);
            if (v < -FS) e = 0;
            else         e = (v + FS) >>> (21 - n);
            if (e > (64'sd1 << n) - 1) e = (64'sd1 << n) - 1;
            ex[s] = int'(e);
            eo[s] = (e == 0) || (e == (64'sd1 << n) - 1);
            vl[s] = (s % 7 != 4);
        end
    endtask

    // Direct code patterns, exhaustive or random; 11 sometimes replaces 10 (R3).
    task automatic gen_codes(input int n, input int ns, input bit exh);
        for (int s = 0; s < ns; s++) begin
            int e = 0;
            int w = 1;
            for (int k = 1; k <= n - 1; k++) begin
                int d = exh ? ((s / w) % 3) : int'($urandom % 3);
                w = w * 3;
                cd[s][k] = (d == 2 && ((s + k) % 4 == 0)) ? 3 : d;
                e = e + (d << (n - 1 - k));
            end
            bb[s] = exh ? (((s / w) % 2) == 1) : 1'($urandom % 2);
            e = e + int'(bb[s]);
            ex[s] = e;
            eo[s] = (e == 0) || (e == (1 << n) - 1);
            vl[s] = 1'b1;
        end
    endtask

    // Stage k sees sample t-k+1 in cycle t; disabled stages get noise (R4).
    task automatic stream(input int req, input int n, input int ns, input string tag);
        for (int t = 0; t < ns + n + 12; t++) begin
            @(negedge clk);
            if (t > 0) begin
                int s = t - 1 - (n - 1);          // R1: N-1 edges after stage 1
                bit ev = (s >= 1 && s < ns) ? vl[s] : 1'b0;
                chk(out_vld == ev, {tag, " R8 R9 valid"}, longint'(out_vld), longint'(ev));
                if (ev) begin
                    chk(out_code == 10'(ex[s]), {tag, " R1 R2 code"}, longint'(out_code), longint'(ex[s]));
                    chk(out_ovf == eo[s], {tag, " R7 ovf"}, longint'(out_ovf), longint'(eo[s]));
                end else begin
                    chk(out_ovf == 1'b0, {tag, " R7 ovf idle"}, longint'(out_ovf), 0);
                end
            end
            if (t == 0) res_sel = 4'(req);
            for (int k = 1; k <= NSTG; k++) begin
                int s = t - k + 1;
                int c = (k <= n - 1 && s >= 0 && s < ns) ? cd[s][k] : int'($urandom % 4);
                stg_code[2*(k-1) +: 2] = 2'(c);
            end
            begin
                int fs = t - (n - 1);
                fin_bit = (fs >= 0 && fs < ns) ? bb[fs] : 1'b0;
            end
            in_vld = (t < ns) ? vl[t] : 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(out_vld == 1'b0, "R10 reset valid", longint'(out_vld), 0);
        chk(out_code == '0, "R10 reset code", longint'(out_code), 0);
        chk(out_ovf == 1'b0, "R10 reset ovf", longint'(out_ovf), 0);
        rst_n = 1'b1;
        repeat (14) @(negedge clk);

        for (int n = 6; n <= 10; n++) begin
            gen_analog(n, 200);
            stream(n, n, 200, "R6");
        end
        gen_codes(6, 486, 1'b1);
        stream(6, 6, 486, "R2 R3 R4");
        gen_codes(10, 80, 1'b0);
        stream(15, 10, 80, "R5 high");
        gen_codes(6, 80, 1'b0);
        stream(3, 6, 80, "R5 low");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        done = 1'b1;
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule